// File: doc/BRIEF.md
# ADC Result Holding Register with Atomic Read Lock

This block holds the result of an analog-to-digital converter and presents it to a byte-wide bus as a high byte and a low byte. The conversion logic supplies a result word and a one-cycle strobe. While the register is unlocked, each strobe loads a new value. An alignment input chooses how the stored bits map onto the two bytes. In right-adjusted form the value is zero-extended from bit 0. In left-adjusted form it is packed against bit 15, so that the high byte alone carries the eight most significant bits.

A two-byte read is kept atomic by a lock. A low-byte read sets the lock, and later strobes then leave the stored value untouched until the high byte is read. A result that arrives during the lock is dropped, not queued. The strobe still goes out one cycle later as a completion pulse, so the flag logic is not affected. A read of the high byte alone never sets the lock. Both byte ports are read-only, and any bus write is ignored. A signed value from a differential input is held bit for bit, with no sign extension.

Top module: `adc_result_hold`

## Requirements
- R1: After reset both byte outputs read 0x00, the completion pulse is low and the register is unlocked.
- R2: With `align_left`=0 the layout is right-adjusted. `hi_byte[1:0]` = result[9:8], `hi_byte[7:2]` = 0 and `lo_byte` = result[7:0].
- R3: With `align_left`=1 the layout is left-adjusted. `hi_byte` = result[9:2], `lo_byte[7:6]` = result[1:0] and `lo_byte[5:0]` = 0.
- R4: A strobe on `res_upd` while unlocked, and with no low-byte read in the same cycle, loads `res_in`. The new value is visible on the byte outputs from the cycle after that strobe.
- R5: A cycle with `rd_lo`=1 and `rd_hi`=0 sets the lock. A strobe in that same cycle, or in any later cycle while the lock holds, does not change the stored value.
- R6: A cycle with `rd_hi`=1 clears the lock, and a strobe in that same cycle is still dropped. A strobe in a later cycle loads again. `rd_lo` and `rd_hi` high in the same cycle leave the register unlocked.
- R7: A high-byte read while unlocked does not set the lock. A strobe in the same cycle as that read, or after it, loads normally.
- R8: A dropped result is lost. After the lock clears, the old value stays until a fresh strobe arrives.
- R9: Strobes on `wr_lo` or `wr_hi`, with any `wr_data`, change neither the stored value nor the lock.
- R10: `done_out` is high in the cycle after each `res_upd` strobe and low otherwise, whether or not the result was dropped.
- R11: A change of `align_left` only remaps the output bytes. Switching back restores the earlier byte values.
- R12: The stored value is the input bit for bit. A value with bit 9 set, such as a negative two's-complement code, reads with `hi_byte[7:2]`=0 when right-adjusted, e.g. 0x200 gives hi 0x02 and lo 0x00, while 0x201 left-adjusted gives hi 0x80 and lo 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_in | input | 10 | Result word from the conversion logic |
| res_upd | input | 1 | One-cycle strobe: `res_in` is valid |
| align_left | input | 1 | 0 = right-adjusted layout, 1 = left-adjusted layout |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| wr_lo | input | 1 | Low-byte write strobe (ignored) |
| wr_hi | input | 1 | High-byte write strobe (ignored) |
| wr_data | input | 8 | Write data (ignored) |
| hi_byte | output | 8 | High byte of the aligned result |
| lo_byte | output | 8 | Low byte of the aligned result |
| done_out | output | 1 | Completion pulse, one cycle after `res_upd` |

## Verification
A load, a lock change and the completion pulse all show up one clock edge after the cycle that caused them. An alignment change reaches the bytes within the same cycle, with no register on the path. Inputs are driven just after a falling edge and held for one full period. After each rising edge the driver pushes the expected bytes and pulse for the cycle it drove, and the monitor compares them at the next falling edge, before the driver moves on. The sequences set the read strobes and the result strobe in the same cycle, unlock and then wait, read the high byte alone, write, and toggle alignment, so each ordering case gets its own entry.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
   typedef enum logic {
      ALIGN_RIGHT = 1'b0,
      ALIGN_LEFT  = 1'b1
   } align_e;
endpackage

// File: rtl/adc_res_lock.sv
module adc_res_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_lo,
   input  logic rd_hi,
   output logic lock_q,
   output logic hold
);
   logic lock_d;

   always_comb begin
      lock_d = lock_q;
      if (rd_hi)
         lock_d = 1'b0;
      else if (rd_lo)
         lock_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else
         lock_q <= lock_d;
   end

   // the low-byte read itself freezes the value it has just sampled
   assign hold = lock_q | rd_lo;

   // R5
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !rd_hi) |=> lock_q);
   // R6
   lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |=> !lock_q);
   // R7
   lock_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q && !rd_lo) |=> !lock_q);
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= din;
   end

   // R1
   store_rst_chk: assert property (@(posedge clk)
      !rst_n |=> (q == '0));
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align
   import adc_res_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int BUS_W = 8
) (
   input  logic [RES_W-1:0] val,
   input  align_e           mode,
   output logic [BUS_W-1:0] hi,
   output logic [BUS_W-1:0] lo
);
   localparam int PAIR_W = 2 * BUS_W;
   localparam int SHIFT  = PAIR_W - RES_W;

   logic [PAIR_W-1:0] right_w;
   logic [PAIR_W-1:0] left_w;
   logic [PAIR_W-1:0] pair_w;

   if (RES_W <= BUS_W || RES_W > PAIR_W) begin : g_bad_width
      $error("RES_W must lie above BUS_W and within two bus bytes");
   end

   for (genvar j = 0; j < PAIR_W; j++) begin : g_bit
      if (j < RES_W) begin : g_r_val
         assign right_w[j] = val[j];
      end else begin : g_r_zero
         assign right_w[j] = 1'b0;
      end
      if (j >= SHIFT) begin : g_l_val
         assign left_w[j] = val[j-SHIFT];
      end else begin : g_l_zero
         assign left_w[j] = 1'b0;
      end
   end

   assign pair_w = (mode == ALIGN_LEFT) ? left_w : right_w;
   assign hi     = pair_w[PAIR_W-1:BUS_W];
   assign lo     = pair_w[BUS_W-1:0];

   // R2
   right_pad_chk: assert final ((mode == ALIGN_LEFT) || ((hi >> (RES_W - BUS_W)) == '0));
   // R3
   left_pad_chk: assert final ((mode != ALIGN_LEFT) || ((lo << (BUS_W - SHIFT)) == '0));
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
   import adc_res_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RES_W-1:0] res_in,
   input  logic             res_upd,
   input  logic             align_left,
   input  logic             rd_lo,
   input  logic             rd_hi,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] hi_byte,
   output logic [BUS_W-1:0] lo_byte,
   output logic             done_out
);
   logic             lock_q;
   logic             hold;
   logic             load;
   logic [RES_W-1:0] stored;
   logic             done_q;
   align_e           mode;

   adc_res_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_lo  (rd_lo),
      .rd_hi  (rd_hi),
      .lock_q (lock_q),
      .hold   (hold)
   );

   assign load = res_upd & ~hold;

   adc_res_store #(.W(RES_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .din   (res_in),
      .q     (stored)
   );

   assign mode = align_left ? ALIGN_LEFT : ALIGN_RIGHT;

   adc_res_align #(.RES_W(RES_W), .BUS_W(BUS_W)) u_align (
      .val  (stored),
      .mode (mode),
      .hi   (hi_byte),
      .lo   (lo_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         done_q <= 1'b0;
      else
         done_q <= res_upd;
   end
   assign done_out = done_q;

   // R4
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_upd && !lock_q && !rd_lo) |=> (stored == $past(res_in)));
   // R5
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q || rd_lo) |=> $stable(stored));
   // R9
   write_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_lo || wr_hi || (wr_data != '0)) && !res_upd) |=> $stable(stored));
   // R10
   done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_upd |=> done_out);
   // R10
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_upd |=> !done_out);
   // R11
   align_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_upd |=> $stable(stored));
endmodule

// File: tb/adc_result_hold_tb.sv
`timescale 1ns/1ps
module adc_result_hold_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] res_in = '0;
   logic       res_upd = 1'b0;
   logic       align_left = 1'b0;
   logic       rd_lo = 1'b0;
   logic       rd_hi = 1'b0;
   logic       wr_lo = 1'b0;
   logic       wr_hi = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] hi_byte;
   logic [7:0] lo_byte;
   logic       done_out;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   typedef struct {
      string      tag;
      logic [7:0] hi;
      logic [7:0] lo;
      logic       done;
   } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   adc_result_hold u_dut (
      .clk(clk), .rst_n(rst_n), .res_in(res_in), .res_upd(res_upd),
      .align_left(align_left), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
      .hi_byte(hi_byte), .lo_byte(lo_byte), .done_out(done_out)
   );

   // layouts as stated in R2 and R3
   function automatic logic [7:0] exp_hi(logic [9:0] v, logic al);
      return al ? v[9:2] : {6'b0, v[9:8]};
   endfunction
   function automatic logic [7:0] exp_lo(logic [9:0] v, logic al);
      return al ? {v[1:0], 6'b0} : v[7:0];
   endfunction

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one cycle of stimulus; the expected state after its rising edge goes to the scoreboard
   task automatic cyc(string tag, logic upd, logic [9:0] rv, logic rl, logic rh,
                      logic al, logic wl, logic wh, logic [7:0] wd,
                      logic [9:0] exp_val, logic exp_done);
      exp_t e;
      @(negedge clk);
      #1;
      res_upd = upd; res_in = rv; rd_lo = rl; rd_hi = rh;
      align_left = al; wr_lo = wl; wr_hi = wh; wr_data = wd;
      @(posedge clk);
      e.tag = tag;
      e.hi = exp_hi(exp_val, al);
      e.lo = exp_lo(exp_val, al);
      e.done = exp_done;
      sb_q.push_back(e);
   endtask

   // monitor: compares each pending entry at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "hi_byte", hi_byte, e.hi);
            check(e.tag, "lo_byte", lo_byte, e.lo);
            check(e.tag, "done_out", {7'b0, done_out}, {7'b0, e.done});
         end
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cyc("R1", 0, 10'h000, 0, 0, 0, 0, 0, 8'h00, 10'h000, 0);
      // R4 R2 load and right layout
      cyc("R4", 1, 10'h2A5, 0, 0, 0, 0, 0, 8'h00, 10'h2A5, 1);
      cyc("R2", 0, 10'h000, 0, 0, 0, 0, 0, 8'h00, 10'h2A5, 0);
      // R3 R11 left layout, then back
      cyc("R3", 0, 10'h000, 0, 0, 1, 0, 0, 8'h00, 10'h2A5, 0);
      cyc("R11", 0, 10'h000, 0, 0, 0, 0, 0, 8'h00, 10'h2A5, 0);
      // R5 R10 low read with coincident strobe, then strobe while locked
      cyc("R5", 1, 10'h111, 1, 0, 0, 0, 0, 8'h00, 10'h2A5, 1);
      cyc("R10", 1, 10'h3FF, 0, 0, 0, 0, 0, 8'h00, 10'h2A5, 1);
      // R6 high read with coincident strobe: dropped
      cyc("R6", 1, 10'h0F0, 0, 1, 0, 0, 0, 8'h00, 10'h2A5, 1);
      // R8 nothing queued
      cyc("R8", 0, 10'h000, 0, 0, 0, 0, 0, 8'h00, 10'h2A5, 0);
      cyc("R8", 0, 10'h000, 0, 0, 1, 0, 0, 8'h00, 10'h2A5, 0);
      // R6 R12 load after unlock, bit 9 set
      cyc("R12", 1, 10'h200, 0, 0, 0, 0, 0, 8'h00, 10'h200, 1);
      cyc("R12", 0, 10'h000, 0, 0, 1, 0, 0, 8'h00, 10'h200, 0);
      // R7 high-only read does not lock
      cyc("R7", 1, 10'h0AA, 0, 1, 0, 0, 0, 8'h00, 10'h0AA, 1);
      cyc("R7", 1, 10'h155, 0, 0, 0, 0, 0, 8'h00, 10'h155, 1);
      cyc("R7", 0, 10'h000, 0, 1, 1, 0, 0, 8'h00, 10'h155, 0);
      cyc("R7", 1, 10'h2C3, 0, 0, 1, 0, 0, 8'h00, 10'h2C3, 1);
      // R9 writes ignored, no lock from them
      cyc("R9", 0, 10'h000, 0, 0, 0, 1, 1, 8'hFF, 10'h2C3, 0);
      cyc("R9", 0, 10'h000, 0, 0, 1, 1, 0, 8'h5A, 10'h2C3, 0);
      cyc("R9", 1, 10'h001, 0, 0, 0, 0, 0, 8'h00, 10'h001, 1);
      // R6 both reads together: no lock
      cyc("R6", 0, 10'h000, 1, 1, 0, 0, 0, 8'h00, 10'h001, 0);
      cyc("R6", 1, 10'h3C3, 0, 0, 0, 0, 0, 8'h00, 10'h3C3, 1);
      // R5 lock over several cycles, then R8 after unlock
      cyc("R5", 0, 10'h000, 1, 0, 1, 0, 0, 8'h00, 10'h3C3, 0);
      cyc("R5", 1, 10'h012, 0, 0, 1, 0, 0, 8'h00, 10'h3C3, 1);
      cyc("R5", 1, 10'h034, 0, 0, 0, 0, 0, 8'h00, 10'h3C3, 1);
      cyc("R6", 0, 10'h000, 0, 1, 0, 0, 0, 8'h00, 10'h3C3, 0);
      cyc("R8", 0, 10'h000, 0, 0, 0, 0, 0, 8'h00, 10'h3C3, 0);
      // R12 left-adjusted signed code
      cyc("R12", 1, 10'h201, 0, 0, 1, 0, 0, 8'h00, 10'h201, 1);
      cyc("R12", 0, 10'h000, 0, 0, 1, 0, 0, 8'h00, 10'h201, 0);
      cyc("R10", 0, 10'h000, 0, 0, 0, 0, 0, 8'h00, 10'h201, 0);
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule